// File: doc/BRIEF.md
# Burst Beat Address Generator

This block sits behind the address channel of a memory-mapped slave. It accepts one burst descriptor at a time through a valid/ready handshake. The descriptor holds a start address, a length field, a beat-size code and a burst kind. The block then presents the address of each beat in turn. It moves to the next beat each time the data side accepts the current one.

Each beat also carries a byte-lane strobe mask and a last-beat flag. The mask marks the active lanes of the data bus for narrow beats and for an unaligned first beat. The block checks the descriptor when it captures it. A descriptor that would run past a 4 KB page, or that cannot be carried out as asked, raises an error flag for the whole burst and is carried out in a safe form.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset `req_ready` is 1 and `beat_valid` is 0. A request is captured on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 and `beat_valid` stays 1 from the cycle after capture until the last beat is accepted. A request held valid while the block is busy is neither captured nor altered.
- R2: A burst has `req_len`+1 beats. `beat_last` is 1 only on the beat whose index equals `req_len`. The cycle after that beat is accepted, `req_ready` is 1 and `beat_valid` is 0.
- R3: Kind code 1 (incrementing): the first beat address is the start address. Each following beat address is the previous address aligned down to the beat size, plus 2^`req_size` bytes.
- R4: Kind code 0 (fixed): every beat of the burst presents the start address and the same strobe mask.
- R5: Kind code 2 (wrapping): the window size is the beat bytes times the beat count, and the window base is the start address aligned down to that size. Each next address is the window base plus ((address + beat bytes) modulo the window size).
- R6: Bit i of `beat_strb` covers byte lane i. Take the lane offset from the low address bits. The mask has a 1 for each lane from that offset up to, but not including, the lane offset aligned down to the beat size plus the beat bytes.
- R7: An incrementing burst whose last byte (aligned start + beats × beat bytes − 1) lies in a different 4 KB page than the start address sets `beat_err` on every beat. The beats are still produced as in R3.
- R8: A wrapping request is treated as incrementing and flagged through `beat_err` if either of these holds: its beat count is not 2, 4, 8 or 16, or its start address is not aligned to the beat size. Kind code 3 is also treated as incrementing and flagged.
- R9: While `beat_valid` is 1 and `beat_ready` is 0, `beat_addr`, `beat_strb`, `beat_last` and `beat_err` hold their values.
- R10: A `req_size` whose byte count exceeds the bus width is flagged through `beat_err`, and the burst uses the full bus width as its beat size.
- R11: Incrementing bursts of up to 256 beats (`req_len` = 255) are carried out in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst descriptor offered |
| req_ready | output | 1 | Block idle and able to take a descriptor |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Beat count minus one |
| req_size | input | 3 | Beat size code, bytes = 2^code |
| req_kind | input | 2 | 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| beat_valid | output | 1 | A beat address is presented |
| beat_ready | input | 1 | Data side accepts the current beat |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| beat_strb | output | DATA_W/8 | Active byte lanes of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| beat_err | output | 1 | Descriptor was flagged at capture |

## Verification
Two functions meet in one cycle: the final beat handshake and the acceptance of the next descriptor. The bench holds the next request valid throughout the previous burst, so the descriptor waits on `req_ready` and is captured on the first edge the block is free. The cycle-level model predicts the single idle cycle between the two bursts and then the new first beat. Stalls are injected by a fixed pattern on `beat_ready`, including stalls on the last beat. Every cycle, the model judges ready, valid, address, strobe, last and error against its own beat queue.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [2:0]          req_size,
  input  logic [1:0]          req_kind,
  output logic                beat_valid,
  input  logic                beat_ready,
  output logic [ADDR_W-1:0]   beat_addr,
  output logic [DATA_W/8-1:0] beat_strb,
  output logic                beat_last,
  output logic                beat_err
);
  localparam int STRB_W = DATA_W / 8;
  localparam int LANE_W = $clog2(STRB_W);
  localparam logic [2:0] MAX_SIZE = 3'(LANE_W);
  localparam int PAGE_W = 12;
  localparam logic [1:0] K_FIXED = 2'd0;
  localparam logic [1:0] K_INCR  = 2'd1;
  localparam logic [1:0] K_WRAP  = 2'd2;

  // descriptor checks, evaluated at capture
  logic              size_bad, kind_bad, wrap_bad, wrap_len_ok, cross_in, err_in;
  logic [2:0]        size_in;
  logic [1:0]        kind_in;
  logic [LEN_W:0]    beats_in;
  logic [ADDR_W-1:0] bytes_in, align_in, wmask_in;
  logic [ADDR_W:0]   end_in;

  assign size_bad    = req_size > MAX_SIZE;
  assign size_in     = size_bad ? MAX_SIZE : req_size;
  assign bytes_in    = ADDR_W'(1) << size_in;
  assign beats_in    = (LEN_W+1)'(req_len) + (LEN_W+1)'(1);
  assign align_in    = req_addr & ~(bytes_in - ADDR_W'(1));
  assign wrap_len_ok = beats_in == (LEN_W+1)'(2) || beats_in == (LEN_W+1)'(4) ||
                       beats_in == (LEN_W+1)'(8) || beats_in == (LEN_W+1)'(16);
  assign kind_bad    = req_kind == 2'd3;
  assign wrap_bad    = req_kind == K_WRAP && (!wrap_len_ok || align_in != req_addr);
  assign kind_in     = (kind_bad || wrap_bad) ? K_INCR : req_kind;
  assign end_in      = (ADDR_W+1)'(align_in) + ((ADDR_W+1)'(beats_in) << size_in)
                       - (ADDR_W+1)'(1);
  assign cross_in    = kind_in == K_INCR &&
                       ((end_in >> PAGE_W) != ((ADDR_W+1)'(req_addr) >> PAGE_W));
  assign err_in      = size_bad || kind_bad || wrap_bad || cross_in;
  assign wmask_in    = (ADDR_W'(beats_in) << size_in) - ADDR_W'(1);

  // burst state
  logic              busy_q, err_q;
  logic [1:0]        kind_q;
  logic [2:0]        size_q;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic [ADDR_W-1:0] cur_q, wmask_q;

  logic [ADDR_W-1:0] bytes_q, step_incr, step_wrap, next_addr;
  logic              fire, at_end;

  assign bytes_q   = ADDR_W'(1) << size_q;
  assign step_incr = (cur_q & ~(bytes_q - ADDR_W'(1))) + bytes_q;
  assign step_wrap = (cur_q & ~wmask_q) | ((cur_q + bytes_q) & wmask_q);
  assign next_addr = kind_q == K_FIXED ? cur_q :
                     kind_q == K_WRAP  ? step_wrap : step_incr;
  assign fire      = busy_q && beat_ready;
  assign at_end    = cnt_q == len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      kind_q  <= K_INCR;
      size_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      cur_q   <= '0;
      wmask_q <= '0;
    end else if (!busy_q && req_valid) begin
      busy_q  <= 1'b1;
      err_q   <= err_in;
      kind_q  <= kind_in;
      size_q  <= size_in;
      len_q   <= req_len;
      cnt_q   <= '0;
      cur_q   <= req_addr;
      wmask_q <= wmask_in;
    end else if (fire) begin
      if (at_end) busy_q <= 1'b0;
      else begin
        cnt_q <= cnt_q + LEN_W'(1);
        cur_q <= next_addr;
      end
    end
  end

  // byte lanes
  logic [LANE_W:0] off, blen, lo, hi;
  assign off  = (LANE_W+1)'(cur_q[LANE_W-1:0]);
  assign blen = (LANE_W+1)'(bytes_q);
  assign lo   = off & ~(blen - (LANE_W+1)'(1));
  assign hi   = lo + blen;

  for (genvar g = 0; g < STRB_W; g++) begin : g_lane
    assign beat_strb[g] = ((LANE_W+1)'(g) >= off) && ((LANE_W+1)'(g) < hi);
  end

  assign req_ready  = !busy_q;
  assign beat_valid = busy_q;
  assign beat_addr  = cur_q;
  assign beat_last  = busy_q && at_end;
  assign beat_err   = busy_q && err_q;

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) &&
    $stable(beat_strb) && $stable(beat_last) && $stable(beat_err));

  p_last_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_last |=> req_ready && !beat_valid);

  p_fixed_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && !beat_last && kind_q == K_FIXED |=>
    $stable(beat_addr) && $stable(beat_strb));

  p_wrap_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && !beat_last && kind_q == K_WRAP |=>
    (beat_addr & ~wmask_q) == $past(beat_addr & ~wmask_q));

  p_incr_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && !beat_last && kind_q == K_INCR && !beat_err |=>
    beat_addr > $past(beat_addr));

  p_err_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && !beat_last |=> $stable(beat_err));

  p_strb_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_strb != '0);
endmodule

// File: tb/burst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic [2:0]  req_size = '0;
  logic [1:0]  req_kind = '0;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic [31:0] beat_addr;
  logic [3:0]  beat_strb;
  logic        beat_last;
  logic        beat_err;

  always #2.5 clk = ~clk;

  burst_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_size(req_size), .req_kind(req_kind),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .beat_strb(beat_strb), .beat_last(beat_last), .beat_err(beat_err));

  typedef struct {
    longint addr;
    int     strb;
    bit     last;
    bit     err;
    string  tag;
    string  etag;
  } beat_t;

  beat_t q[$];
  int    n_run = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    done = 0;
  bit    stalled_prev = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic void build(longint a0, int len, int size, int kind);
    bit     err = 0;
    string  etag = "none";
    string  tag;
    int     sz = size;
    longint bytes, n, a, lastb, total, base;
    if (sz > 2) begin err = 1; etag = "R10"; sz = 2; end
    bytes = 64'd1 << sz;
    n = len + 1;
    if (kind == 3) begin err = 1; etag = "R8"; kind = 1; end
    if (kind == 2 && (!(n == 2 || n == 4 || n == 8 || n == 16) || (a0 % bytes) != 0)) begin
      err = 1; etag = "R8"; kind = 1;
    end
    if (kind == 1) begin
      lastb = (a0 / bytes) * bytes + n * bytes - 1;
      if ((lastb >> 12) != (a0 >> 12)) begin err = 1; etag = "R7"; end
    end
    tag = kind == 0 ? "R4" : kind == 2 ? "R5" : (n > 16 ? "R11" : "R3");
    a = a0;
    total = bytes * n;
    for (int i = 0; i < n; i++) begin
      beat_t b;
      int off, lo, m;
      off = int'(a % 4);
      lo = off & ~int'(bytes - 1);
      m = 0;
      for (int l = 0; l < 4; l++) if (l >= off && l < lo + bytes) m |= (1 << l);
      b.addr = a; b.strb = m; b.last = (i == n - 1); b.err = err; b.tag = tag; b.etag = etag;
      q.push_back(b);
      if (kind == 1) a = ((a / bytes) * bytes + bytes) & 64'hFFFF_FFFF;
      else if (kind == 2) begin
        base = a & ~(total - 1);
        a = base | ((a + bytes) & (total - 1));
      end
    end
  endfunction

  // reference model: advances on the same edges as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      stalled_prev <= 0;
    end else begin
      stalled_prev <= (q.size() != 0) && !beat_ready;
      if (q.size() != 0) begin
        if (beat_ready) void'(q.pop_front());
      end else if (req_valid) build(req_addr, req_len, req_size, req_kind);
    end
  end

  // stall pattern and per-cycle comparison away from the rising edge
  always @(negedge clk) begin
    cyc++;
    beat_ready = (cyc % 5 != 2) && (cyc % 7 != 3);
    if (rst_n && !done) begin
      chk(req_ready == (q.size() == 0), "R1", "req_ready", req_ready, q.size() == 0);
      chk(beat_valid == (q.size() != 0), "R1", "beat_valid", beat_valid, q.size() != 0);
      if (q.size() != 0 && beat_valid) begin
        chk(beat_addr == q[0].addr[31:0], stalled_prev ? "R9" : q[0].tag, "beat_addr",
            beat_addr, q[0].addr);
        chk(beat_strb == q[0].strb[3:0], "R6", "beat_strb", beat_strb, q[0].strb);
        chk(beat_last == q[0].last, "R2", "beat_last", beat_last, q[0].last);
        chk(beat_err == q[0].err, q[0].err ? q[0].etag : "R7", "beat_err", beat_err, q[0].err);
      end
    end
  end

  task automatic send(input logic [31:0] a, input int len, input int size, input int kind);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = 8'(len);
    req_size = 3'(size); req_kind = 2'(kind);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
    chk(beat_valid == 1'b0, "R1", "reset beat_valid", beat_valid, 0);
    rst_n = 1'b1;
    send(32'h100, 3, 2, 1);       // R3 aligned words
    send(32'h1003, 2, 2, 1);      // R3/R6 unaligned start
    send(32'h21, 5, 0, 1);        // R6 byte beats
    send(32'h42, 3, 1, 1);        // R6 halfword beats
    send(32'h305, 3, 0, 0);       // R4 fixed
    send(32'h38, 3, 2, 2);        // R5 four-beat wrap
    send(32'h1A, 7, 1, 2);        // R5 eight-beat halfword wrap
    send(32'h40, 2, 2, 2);        // R8 three-beat wrap
    send(32'h39, 3, 2, 2);        // R8 unaligned wrap
    send(32'hFF8, 3, 2, 1);       // R7 page crossing
    send(32'hFF0, 3, 2, 1);       // R7 ends exactly at page end
    send(32'h500, 2, 3, 1);       // R10 oversize beat
    send(32'h2000, 255, 0, 1);    // R11 longest burst
    send(32'h600, 1, 2, 3);       // R8 reserved kind
    send(32'hFFFF_FFF0, 3, 2, 0); // R4 fixed at top of space
    while (q.size() != 0 || !req_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule